// File: doc/BRIEF.md
# Two-Rate Receive DC Offset Controller

This block removes the DC offset from a signed I/Q sample stream during a receive burst. Samples arrive with a valid strobe, nominally at 13 MHz. A rising edge on the receive enable starts a burst. At that edge both per-channel offset estimates clear, and a shared count of valid samples restarts from zero.

For a programmed number of samples the estimator adapts quickly, using a short leaky-accumulator shift. After that fast phase it does one of two things. By default it freezes both estimates for the rest of the burst. When slow tracking is enabled, it keeps adapting with a longer shift, and only on every N-th valid sample, where N is programmable. The corrected output is the sample minus the integer part of the estimate, saturated to the input range.

Two independent blanking windows, counted in valid samples from the start of the burst, control what is seen during startup. The first one zeroes the samples that feed the estimator. The second one zeroes the corrected I/Q output.

Top module: `rx_dc_offset_ctrl`

## Requirements
- R1: A rising edge of `rx_en_i` clears both estimates to zero and restarts the valid-sample index, so the first sample of a new burst is corrected by an offset of zero.
- R2: During the first `fast_len_i` valid samples of a burst, every sample updates each estimate as `est += ((xe << FRAC_W) - est) >>> K_FAST`. Here `est` is fixed point with `FRAC_W` fraction bits and `xe` is the estimator input.
- R3: After the fast phase with `slow_en_i` = 0, both estimates stay unchanged until `rx_en_i` goes low or a new burst starts.
- R4: After the fast phase with `slow_en_i` = 1, an update with shift `K_SLOW` occurs on every N-th valid sample of the slow phase. The first update is on the N-th sample. N equals `slow_div_i` for values 1 to 48, and values 0 or above 48 select 48.
- R5: While the valid-sample index is below `est_blank_len_i`, the estimator input `xe` is zero instead of the sample.
- R6: While the valid-sample index is below `out_blank_len_i`, both outputs for that sample are zero.
- R7: `out_valid_o` is `in_valid_i` delayed by one clock. Each output sample appears one clock after its input and equals `x - (est >>> FRAC_W)`, using the estimate before that sample's update. The output data is zero when no sample is accepted.
- R8: While `rx_en_i` is low, both outputs are zero and neither estimate changes.
- R9: The subtraction saturates to the signed `DATA_W` range, for example +127 and -128 for 8 bits, instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive enable; a rising edge starts a burst |
| in_valid_i | input | 1 | Input sample strobe |
| in_i_i | input | DATA_W | In-phase sample, signed |
| in_q_i | input | DATA_W | Quadrature sample, signed |
| slow_en_i | input | 1 | Keep tracking in slow mode after the fast phase |
| fast_len_i | input | CNT_W | Fast-phase length in valid samples |
| est_blank_len_i | input | CNT_W | Estimator-input blanking length in valid samples |
| out_blank_len_i | input | CNT_W | Output blanking length in valid samples |
| slow_div_i | input | DIV_W | Slow update divider N |
| out_valid_o | output | 1 | Output sample strobe |
| out_i_o | output | DATA_W | Corrected in-phase sample |
| out_q_o | output | DATA_W | Corrected quadrature sample |

## Verification
The bench builds the block with 8-bit samples, an 8-bit sample index, 4 fraction bits, a fast shift of 2 and a slow shift of 4. At this size a bench integer model can track the estimates exactly, cycle by cycle. The input extremes of +127 and -128 are easy to reach, so saturation in both directions shows up after a short fast phase. The slow divider is swept over 0, 1, 2, 3, 5, 47, 48 and 49, which covers the every-sample case, the ceiling and both out-of-range encodings within a few hundred samples each. Short blanking windows and gapped valid patterns check that both windows count valid samples only.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;
  localparam int unsigned SLOW_DIV_MAX = 48;

  typedef enum logic [1:0] {
    PH_FAST = 2'd0,
    PH_SLOW = 2'd1,
    PH_HOLD = 2'd2
  } dcoc_phase_e;
endpackage

// File: rtl/dcoc_timer.sv
module dcoc_timer
  import dcoc_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned DIV_MAX = SLOW_DIV_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             in_valid_i,
  input  logic             slow_en_i,
  input  logic [CNT_W-1:0] fast_len_i,
  input  logic [CNT_W-1:0] est_blank_len_i,
  input  logic [CNT_W-1:0] out_blank_len_i,
  input  logic [DIV_W-1:0] slow_div_i,
  output logic             rise_o,
  output logic             active_o,
  output logic             upd_o,
  output logic             slow_sel_o,
  output logic             est_blank_o,
  output logic             out_blank_o
);
  localparam logic [DIV_W-1:0] DIV_CAP = DIV_W'(DIV_MAX);

  logic             rx_q;
  logic [CNT_W-1:0] idx_q, idx_cur, idx_inc;
  logic [DIV_W-1:0] presc_q, presc_cur, presc_nxt, div_eff;
  logic             slow_tick;
  dcoc_phase_e      phase;

  assign rise_o    = rx_en_i & ~rx_q;
  assign active_o  = rx_en_i & in_valid_i;
  assign idx_cur   = rise_o ? '0 : idx_q;
  assign presc_cur = rise_o ? '0 : presc_q;
  assign idx_inc   = (idx_cur == '1) ? idx_cur : idx_cur + 1'b1;

  always_comb begin
    if (slow_div_i == '0 || slow_div_i > DIV_CAP) div_eff = DIV_CAP;
    else                                          div_eff = slow_div_i;
  end

  always_comb begin
    if (idx_cur < fast_len_i) phase = PH_FAST;
    else if (slow_en_i)       phase = PH_SLOW;
    else                      phase = PH_HOLD;
  end

  assign slow_tick   = (phase == PH_SLOW) && (presc_cur == div_eff - 1'b1);
  assign upd_o       = active_o && ((phase == PH_FAST) || slow_tick);
  assign slow_sel_o  = (phase != PH_FAST);
  assign est_blank_o = idx_cur < est_blank_len_i;
  assign out_blank_o = idx_cur < out_blank_len_i;

  always_comb begin
    presc_nxt = presc_cur;
    if (phase == PH_SLOW) presc_nxt = slow_tick ? '0 : presc_cur + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q    <= 1'b0;
      idx_q   <= '0;
      presc_q <= '0;
    end else begin
      rx_q <= rx_en_i;
      if (active_o) begin
        idx_q   <= idx_inc;
        presc_q <= presc_nxt;
      end else begin
        idx_q   <= idx_cur;
        presc_q <= presc_cur;
      end
    end
  end
endmodule

// File: rtl/dcoc_chan.sv
module dcoc_chan #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned K_FAST = 2,
  parameter int unsigned K_SLOW = 5,
  localparam int unsigned EST_W = DATA_W + FRAC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     active_i,
  input  logic                     upd_i,
  input  logic                     slow_sel_i,
  input  logic                     est_blank_i,
  input  logic                     out_blank_i,
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic signed [EST_W-1:0]  est_o
);
  localparam int unsigned DIF_W = EST_W + 1;

  logic signed [EST_W-1:0]  est_q, est_cur, est_nxt;
  logic signed [DATA_W-1:0] xe, est_int, y_d;
  logic signed [DIF_W-1:0]  x_fx, diff, step;
  logic signed [DATA_W:0]   corr;

  assign est_cur = clear_i ? '0 : est_q;
  assign xe      = est_blank_i ? '0 : x_i;
  assign x_fx    = {xe[DATA_W-1], xe, {FRAC_W{1'b0}}};
  assign diff    = x_fx - {est_cur[EST_W-1], est_cur};
  assign step    = slow_sel_i ? (diff >>> K_SLOW) : (diff >>> K_FAST);
  // moves toward the input, so the sum always fits EST_W
  assign est_nxt = est_cur + EST_W'(step);

  assign est_int = est_cur[EST_W-1:FRAC_W];
  assign corr    = {x_i[DATA_W-1], x_i} - {est_int[DATA_W-1], est_int};

  always_comb begin
    if (corr[DATA_W] != corr[DATA_W-1])
      y_d = corr[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    else
      y_d = corr[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      est_q <= '0;
      y_o   <= '0;
    end else begin
      est_q <= (active_i && upd_i) ? est_nxt : est_cur;
      y_o   <= (active_i && !out_blank_i) ? y_d : '0;
    end
  end

  assign est_o = est_q;
endmodule

// File: rtl/rx_dc_offset_ctrl.sv
module rx_dc_offset_ctrl
  import dcoc_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned FRAC_W  = 6,
  parameter int unsigned K_FAST  = 2,
  parameter int unsigned K_SLOW  = 5,
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned DIV_MAX = SLOW_DIV_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_i_i,
  input  logic [DATA_W-1:0] in_q_i,
  input  logic              slow_en_i,
  input  logic [CNT_W-1:0]  fast_len_i,
  input  logic [CNT_W-1:0]  est_blank_len_i,
  input  logic [CNT_W-1:0]  out_blank_len_i,
  input  logic [DIV_W-1:0]  slow_div_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_i_o,
  output logic [DATA_W-1:0] out_q_o
);
  localparam int unsigned EST_W = DATA_W + FRAC_W;
  localparam int unsigned N_CH  = 2;

  logic rise, active, upd, slow_sel, est_blank, out_blank;
  logic signed [DATA_W-1:0] x_w [N_CH];
  logic signed [DATA_W-1:0] y_w [N_CH];
  logic signed [EST_W-1:0]  est_w [N_CH];
  logic [EST_W-1:0] est_i_w, est_q_w;

  dcoc_timer #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_timer (
    .clk_i, .rst_ni, .rx_en_i, .in_valid_i, .slow_en_i,
    .fast_len_i, .est_blank_len_i, .out_blank_len_i, .slow_div_i,
    .rise_o(rise), .active_o(active), .upd_o(upd), .slow_sel_o(slow_sel),
    .est_blank_o(est_blank), .out_blank_o(out_blank)
  );

  assign x_w[0] = in_i_i;
  assign x_w[1] = in_q_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dcoc_chan #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .K_FAST(K_FAST), .K_SLOW(K_SLOW)) u_chan (
      .clk_i, .rst_ni,
      .clear_i(rise), .active_i(active), .upd_i(upd), .slow_sel_i(slow_sel),
      .est_blank_i(est_blank), .out_blank_i(out_blank),
      .x_i(x_w[c]), .y_o(y_w[c]), .est_o(est_w[c])
    );
  end

  assign out_i_o = y_w[0];
  assign out_q_o = y_w[1];
  assign est_i_w = est_w[0];
  assign est_q_w = est_w[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= in_valid_i;
  end
endmodule

// File: rtl/rx_dc_offset_ctrl_chk.sv
module rx_dc_offset_ctrl_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned EST_W  = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              in_valid_i,
  input logic              slow_en_i,
  input logic [CNT_W-1:0]  fast_len_i,
  input logic [CNT_W-1:0]  out_blank_len_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_i_o,
  input logic [DATA_W-1:0] out_q_o,
  input logic [EST_W-1:0]  est_i_w,
  input logic [EST_W-1:0]  est_q_w
);
  logic             past_ok, chk_rx_q;
  logic [CNT_W-1:0] chk_idx_q, chk_idx_cur;

  assign chk_idx_cur = (rx_en_i && !chk_rx_q) ? '0 : chk_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok   <= 1'b0;
      chk_rx_q  <= 1'b0;
      chk_idx_q <= '0;
    end else begin
      past_ok  <= 1'b1;
      chk_rx_q <= rx_en_i;
      if (rx_en_i && in_valid_i && chk_idx_cur != '1) chk_idx_q <= chk_idx_cur + 1'b1;
      else                                           chk_idx_q <= chk_idx_cur;
    end
  end

  AST_VALID_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> out_valid_o == $past(in_valid_i)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!rx_en_i) |-> (out_i_o == '0 && out_q_o == '0)); // R8

  AST_IDLE_NO_ADAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> ($stable(est_i_w) && $stable(est_q_w))); // R8

  AST_OUT_BLANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(rx_en_i && in_valid_i && (chk_idx_cur < out_blank_len_i))
    |-> (out_i_o == '0 && out_q_o == '0)); // R6

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_i && chk_rx_q && !slow_en_i && (chk_idx_q >= fast_len_i)
    |=> ($stable(est_i_w) && $stable(est_q_w))); // R3
endmodule

bind rx_dc_offset_ctrl rx_dc_offset_ctrl_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .EST_W(DATA_W + FRAC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .in_valid_i(in_valid_i),
  .slow_en_i(slow_en_i), .fast_len_i(fast_len_i), .out_blank_len_i(out_blank_len_i),
  .out_valid_o(out_valid_o), .out_i_o(out_i_o), .out_q_o(out_q_o),
  .est_i_w(est_i_w), .est_q_w(est_q_w)
);

// File: tb/rx_dc_offset_ctrl_bench.sv
`timescale 1ns/1ps
module rx_dc_offset_ctrl_bench;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int FR = 4;
  localparam int KF = 2;
  localparam int KS = 4;
  localparam int VW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0, in_valid = 1'b0, slow_en = 1'b0;
  logic [DW-1:0] in_i = '0, in_q = '0;
  logic [CW-1:0] fast_len = '0, eb_len = '0, ob_len = '0;
  logic [VW-1:0] slow_div = '0;
  logic          out_valid;
  logic [DW-1:0] out_i, out_q;

  always #4 clk = ~clk;

  rx_dc_offset_ctrl #(
    .DATA_W(DW), .CNT_W(CW), .FRAC_W(FR), .K_FAST(KF), .K_SLOW(KS), .DIV_W(VW)
  ) u_rx_dc_offset_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .in_valid_i(in_valid),
    .in_i_i(in_i), .in_q_i(in_q), .slow_en_i(slow_en), .fast_len_i(fast_len),
    .est_blank_len_i(eb_len), .out_blank_len_i(ob_len), .slow_div_i(slow_div),
    .out_valid_o(out_valid), .out_i_o(out_i), .out_q_o(out_q)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  int m_est [2];
  int m_idx = 0, m_presc = 0;
  bit m_rx_prev = 0;
  bit pend = 0;
  int e_v, e_i, e_q;
  string e_tag;

  function automatic int sat(int v);
    int hi = (1 << (DW - 1)) - 1;
    int lo = -(1 << (DW - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int sx(logic [DW-1:0] v);
    return int'(signed'(v));
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check_pending();
    if (pend) begin
      n_chk++;
      if (int'(out_valid) != e_v || sx(out_i) != e_i || sx(out_q) != e_q) begin
        n_bad++;
        $display("FAIL %s: got v=%0d i=%0d q=%0d, expected v=%0d i=%0d q=%0d",
                 e_tag, out_valid, sx(out_i), sx(out_q), e_v, e_i, e_q);
      end
    end
  endtask

  task automatic step(bit rx, bit v, int xi, int xq, string tag);
    int xs [2];
    int o [2];
    bit upd;
    int k;
    int neff;
    check_pending();
    rx_en = rx; in_valid = v; in_i = DW'(xi); in_q = DW'(xq);
    xs[0] = xi; xs[1] = xq;
    if (rx && !m_rx_prev) begin
      m_est[0] = 0; m_est[1] = 0; m_idx = 0; m_presc = 0;
    end
    o[0] = 0; o[1] = 0;
    e_tag = tag;
    if (!rx) e_tag = "R8";
    if (rx && v) begin
      neff = (slow_div == 0 || slow_div > 48) ? 48 : int'(slow_div);
      upd = 0; k = KF;
      if (m_idx < int'(fast_len)) upd = 1;
      else if (slow_en) begin
        k = KS;
        if (m_presc == neff - 1) begin upd = 1; m_presc = 0; end
        else m_presc++;
      end
      for (int c = 0; c < 2; c++) begin
        int xe = (m_idx < int'(eb_len)) ? 0 : xs[c];
        o[c] = (m_idx < int'(ob_len)) ? 0 : sat(xs[c] - (m_est[c] >>> FR));
        if (upd) m_est[c] = m_est[c] + (((xe <<< FR) - m_est[c]) >>> k);
      end
      if (m_idx < int'(ob_len) && tag != "R1") e_tag = {tag, "/R6"};
      if (m_idx < (1 << CW) - 1) m_idx++;
    end
    m_rx_prev = rx;
    e_v = int'(v); e_i = o[0]; e_q = o[1];
    pend = 1;
    @(negedge clk);
  endtask

  task automatic cfg(int fl, int eb, int ob, bit se, int dv);
    fast_len = CW'(fl); eb_len = CW'(eb); ob_len = CW'(ob);
    slow_en = se; slow_div = VW'(dv);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got cycle=%0d, expected end before 100000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int lf;
    int divs [8] = '{0, 1, 2, 3, 5, 47, 48, 49};
    m_est[0] = 0; m_est[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
      n_bad++;
      $display("FAIL R7 reset: got v=%0d i=%0d q=%0d, expected 0 0 0", out_valid, sx(out_i), sx(out_q));
    end

    // R8: idle with valid samples
    cfg(16, 0, 0, 0, 0);
    for (int n = 0; n < 6; n++) step(0, 1, 50 + n, -40, "R8");

    // R2 fast phase then R3 hold on constant offset
    for (int n = 0; n < 16; n++) step(1, 1, 20, -30, "R2");
    for (int n = 0; n < 40; n++) step(1, 1, 20 + (n % 9) - 4, -30 + (n % 5), "R3");
    // R8: burst ends, estimates must not move
    for (int n = 0; n < 5; n++) step(0, 1, 100, 100, "R8");
    // R1: new burst restarts from zero offset
    step(1, 1, 50, -50, "R1");
    for (int n = 0; n < 10; n++) step(1, 1, 50, -50, "R2");
    step(0, 0, 0, 0, "R8");

    // R5/R6: blanking windows with gapped valid
    cfg(10, 5, 7, 1, 1);
    lf = 8'h5a;
    for (int n = 0; n < 60; n++) begin
      lf = ((lf << 1) | (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1)) & 8'hff;
      step(1, (lf & 3) != 0, (n * 29) % 160 - 60, 70 - (n * 11) % 120, "R5");
    end
    step(0, 0, 0, 0, "R8");

    // R4: slow divider sweep, including out-of-range encodings
    foreach (divs[d]) begin
      cfg(4, 0, 0, 1, divs[d]);
      for (int n = 0; n < 130; n++)
        step(1, (n % 7) != 3, (n * 37) % 200 - 100, 60 - (n * 13) % 90, "R4");
      step(0, 0, 0, 0, "R8");
    end

    // R9: saturation both ways
    cfg(40, 0, 0, 0, 0);
    for (int n = 0; n < 40; n++) step(1, 1, -120, 120, "R9");
    for (int n = 0; n < 6; n++) step(1, 1, 120, -120, "R9");
    for (int n = 0; n < 4; n++) step(1, 1, 127, -128, "R9");
    step(0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");
    check_pending();
    pend = 0;

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule